// File: doc/BRIEF.md
# Deferred Condition Flag Evaluator

This block rebuilds the integer condition flags of a 32-bit datapath after the fact. The execution stage does not produce flags itself; it keeps the result of the last flag-setting operation, the source operand that went into it and a small code that names the kind of operation. When flags are needed, the three values are presented here together with the flags that were current before. One clock later the block returns a packed flag word holding extend (X), negative (N), zero (Z), overflow (V) and carry (C).

Operations can be plain or extended. Extended add and subtract take the incoming X as a carry or borrow, which lets a multi-word sum be built one word at a time. Across such a chain the zero flag is sticky: once any word is nonzero, Z stays cleared for the rest of the chain. An unused class code does not stop anything. It yields an all-zero flag word and raises an error strobe for one cycle.

Top module: `cond_flag_unit`

## Requirements
- R1: While reset is held, and until the first request after it, `flags_out` is 0 and `out_valid` and `bad_class` are 0.
- R2: A request sampled with `req_valid` high is answered on the next rising clock edge. `out_valid` is high for that one cycle. Without a request, `flags_out` keeps its value and `out_valid` and `bad_class` stay low. The flag word is `{X,N,Z,V,C}` in bits 4:0 of both `flags_in` and `flags_out`.
- R3: Class 0 (preset) copies `res_op[4:0]` into the flag word unchanged.
- R4: For every class except preset and the two compares, Z is 1 exactly when `res_op` is zero, and N is 1 exactly when `res_op` is nonzero with bit 31 set. Class 1 (logic) clears V and C and keeps X from `flags_in`.
- R5: Class 2 (add). The addends are `res_op - src_op` and `src_op`. C is 1 when `res_op < src_op` unsigned. V is 1 when both addends have the same sign and the sign of `res_op` differs from it. X equals the new C.
- R6: Class 3 (subtract). The minuend is `res_op + src_op`. C is 1 when the minuend is unsigned-less than `src_op`. V is 1 when minuend and `src_op` differ in sign and `res_op` differs in sign from the minuend. X equals the new C.
- R7: Class 4 (byte compare) and class 5 (word compare) apply the subtract rules of R6 to the low 8 or 16 bits only. N and Z are taken at that width, and X keeps its incoming value.
- R8: Class 6 (extended add). When incoming X is 1, the addends are `res_op - src_op - 1` and `src_op`, and C is 1 when `res_op <= src_op`. When incoming X is 0, the R5 rules apply. X equals the new C.
- R9: Class 7 (extended subtract). When incoming X is 1, the minuend is `res_op + src_op + 1`, and C is 1 when the minuend is `<= src_op`. When incoming X is 0, the R6 rules apply. X equals the new C.
- R10: For classes 6 and 7, the new Z is the AND of the zero test on `res_op` and the incoming Z, so one nonzero word clears Z for the remainder of a chain.
- R11: Class 8 (shift). V is 0, C is 1 exactly when `src_op` (the bit shifted out) is nonzero, and X equals the new C.
- R12: Class codes 9 to 15 give a flag word of 0 and raise `bad_class` for exactly the one answering cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Evaluate the operands presented this cycle |
| op_class | input | 4 | Operation class code (0 to 8 valid) |
| res_op | input | 32 | Kept result operand (or a preset flag word for class 0) |
| src_op | input | 32 | Kept source operand (or the shifted-out bit for class 8) |
| flags_in | input | 5 | Flags before the operation, {X,N,Z,V,C} |
| flags_out | output | 5 | Evaluated flags, {X,N,Z,V,C} |
| out_valid | output | 1 | Flag word updated this cycle |
| bad_class | output | 1 | One-cycle strobe for an unused class code |

## Verification
Every result comes out of a single register stage. The flag word, `out_valid` and `bad_class` for a request therefore appear one rising edge after the cycle in which `req_valid` was high. The bench drives each request on a falling edge and compares all three outputs on the next falling edge. That is half a period after the answering edge and half a period before the next one. It then leaves one idle cycle and checks, again on a falling edge, that the flag word has held and that both strobes have dropped. Chained extended words take the previous answer from `flags_out` as the next `flags_in`, so the sticky zero flag is seen across whole chains.

// File: rtl/cflag_pkg.sv
package cflag_pkg;

  localparam int FLAG_W  = 5;
  localparam int CLASS_W = 4;

  // Operation class codes, decoded by the selector.
  localparam logic [CLASS_W-1:0] CLS_PRESET = 4'd0;
  localparam logic [CLASS_W-1:0] CLS_LOGIC  = 4'd1;
  localparam logic [CLASS_W-1:0] CLS_ADD    = 4'd2;
  localparam logic [CLASS_W-1:0] CLS_SUB    = 4'd3;
  localparam logic [CLASS_W-1:0] CLS_CMP8   = 4'd4;
  localparam logic [CLASS_W-1:0] CLS_CMP16  = 4'd5;
  localparam logic [CLASS_W-1:0] CLS_ADDX   = 4'd6;
  localparam logic [CLASS_W-1:0] CLS_SUBX   = 4'd7;
  localparam logic [CLASS_W-1:0] CLS_SHIFT  = 4'd8;
  localparam logic [CLASS_W-1:0] CLS_LAST   = CLS_SHIFT;

  // Packed flag word, X in bit 4 down to C in bit 0.
  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } cflag_word_t;

endpackage

// File: rtl/cflag_lane.sv
// One arithmetic flag lane: N, Z, V and C of an add or subtract at width W,
// rebuilt from the kept result and source operand plus a carry-in.
module cflag_lane #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic [W-1:0] src_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o,
  output logic         c_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] cin_ext;
  logic [W-1:0] add_lhs;   // first addend recovered for add
  logic [W-1:0] sub_lhs;   // minuend recovered for subtract
  logic [W-1:0] add_vmask;
  logic [W-1:0] sub_vmask;
  logic         add_c;
  logic         sub_c;

  assign cin_ext   = {{(W-1){1'b0}}, cin_i};
  assign add_lhs   = res_i - src_i - cin_ext;
  assign sub_lhs   = res_i + src_i + cin_ext;
  assign add_vmask = (src_i ^ res_i) & ~(add_lhs ^ src_i);
  assign sub_vmask = (sub_lhs ^ res_i) & (sub_lhs ^ src_i);

  always_comb begin
    if (cin_i) begin
      add_c = (res_i <= src_i);
      sub_c = (sub_lhs <= src_i);
    end else begin
      add_c = (res_i < src_i);
      sub_c = (sub_lhs < src_i);
    end
  end

  assign n_o = res_i[MSB];
  assign z_o = ~|res_i;
  assign v_o = sub_i ? sub_vmask[MSB] : add_vmask[MSB];
  assign c_o = sub_i ? sub_c : add_c;

endmodule

// File: rtl/cflag_select.sv
// Picks the flag word for the requested class from the lanes and the
// operand tests, applies the extend and sticky-zero policy, flags bad codes.
module cflag_select
  import cflag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = 3
) (
  input  logic [CLASS_W-1:0] cls_i,
  input  logic [DATA_W-1:0]  res_i,
  input  logic [DATA_W-1:0]  src_i,
  input  cflag_word_t        prev_i,
  input  logic [LANES-1:0]   lane_n_i,
  input  logic [LANES-1:0]   lane_z_i,
  input  logic [LANES-1:0]   lane_v_i,
  input  logic [LANES-1:0]   lane_c_i,
  output cflag_word_t        flags_o,
  output logic               bad_o
);

  localparam int LANE_FULL = 0;
  localparam int LANE_B    = 1;
  localparam int LANE_H    = 2;
  localparam int MSB       = DATA_W - 1;

  logic res_zero;
  logic res_neg;
  logic src_any;

  assign res_zero = ~|res_i;
  assign res_neg  = res_i[MSB];
  assign src_any  = |src_i;

  always_comb begin
    flags_o = '0;
    bad_o   = 1'b0;
    unique case (cls_i)
      CLS_PRESET: begin
        flags_o = cflag_word_t'(res_i[FLAG_W-1:0]);
      end
      CLS_LOGIC: begin
        flags_o.x = prev_i.x;
        flags_o.n = res_neg;
        flags_o.z = res_zero;
      end
      CLS_ADD, CLS_SUB: begin
        flags_o.n = lane_n_i[LANE_FULL];
        flags_o.z = lane_z_i[LANE_FULL];
        flags_o.v = lane_v_i[LANE_FULL];
        flags_o.c = lane_c_i[LANE_FULL];
        flags_o.x = lane_c_i[LANE_FULL];
      end
      CLS_CMP8: begin
        flags_o.x = prev_i.x;
        flags_o.n = lane_n_i[LANE_B];
        flags_o.z = lane_z_i[LANE_B];
        flags_o.v = lane_v_i[LANE_B];
        flags_o.c = lane_c_i[LANE_B];
      end
      CLS_CMP16: begin
        flags_o.x = prev_i.x;
        flags_o.n = lane_n_i[LANE_H];
        flags_o.z = lane_z_i[LANE_H];
        flags_o.v = lane_v_i[LANE_H];
        flags_o.c = lane_c_i[LANE_H];
      end
      CLS_ADDX, CLS_SUBX: begin
        flags_o.n = lane_n_i[LANE_FULL];
        flags_o.z = lane_z_i[LANE_FULL] & prev_i.z;
        flags_o.v = lane_v_i[LANE_FULL];
        flags_o.c = lane_c_i[LANE_FULL];
        flags_o.x = lane_c_i[LANE_FULL];
      end
      CLS_SHIFT: begin
        flags_o.n = res_neg;
        flags_o.z = res_zero;
        flags_o.c = src_any;
        flags_o.x = src_any;
      end
      default: begin
        bad_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/cond_flag_unit.sv
// Deferred condition flag evaluator: one register stage after the lanes.
module cond_flag_unit
  import cflag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [CLASS_W-1:0]   op_class,
  input  logic [DATA_W-1:0]    res_op,
  input  logic [DATA_W-1:0]    src_op,
  input  logic [FLAG_W-1:0]    flags_in,
  output logic [FLAG_W-1:0]    flags_out,
  output logic                 out_valid,
  output logic                 bad_class
);

  localparam int LANES = 3;

  // Reset: asserted at once, released through two flops.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cflag_word_t prev_w;
  logic        full_sub;
  logic        full_cin;

  assign prev_w   = cflag_word_t'(flags_in);
  assign full_sub = (op_class == CLS_SUB) || (op_class == CLS_SUBX);
  assign full_cin = ((op_class == CLS_ADDX) || (op_class == CLS_SUBX)) & prev_w.x;

  logic [LANES-1:0] lane_n;
  logic [LANES-1:0] lane_z;
  logic [LANES-1:0] lane_v;
  logic [LANES-1:0] lane_c;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? DATA_W : ((g == 1) ? BYTE_W : HALF_W);
    logic lane_cin;
    logic lane_sub;
    if (g == 0) begin : g_full
      assign lane_cin = full_cin;
      assign lane_sub = full_sub;
    end else begin : g_cmp
      assign lane_cin = 1'b0;
      assign lane_sub = 1'b1;
    end
    cflag_lane #(.W(LW)) u_lane (
      .res_i (res_op[LW-1:0]),
      .src_i (src_op[LW-1:0]),
      .cin_i (lane_cin),
      .sub_i (lane_sub),
      .n_o   (lane_n[g]),
      .z_o   (lane_z[g]),
      .v_o   (lane_v[g]),
      .c_o   (lane_c[g])
    );
  end

  cflag_word_t sel_flags;
  logic        sel_bad;

  cflag_select #(.DATA_W(DATA_W), .LANES(LANES)) u_sel (
    .cls_i    (op_class),
    .res_i    (res_op),
    .src_i    (src_op),
    .prev_i   (prev_w),
    .lane_n_i (lane_n),
    .lane_z_i (lane_z),
    .lane_v_i (lane_v),
    .lane_c_i (lane_c),
    .flags_o  (sel_flags),
    .bad_o    (sel_bad)
  );

  // Next state
  logic [FLAG_W-1:0] flags_d, flags_q;
  logic              vld_d, vld_q;
  logic              bad_d, bad_q;

  always_comb begin
    flags_d = flags_q;
    if (req_valid) begin
      flags_d = sel_flags;
    end
    vld_d = req_valid;
    bad_d = req_valid & sel_bad;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q <= '0;
      vld_q   <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      vld_q   <= vld_d;
      bad_q   <= bad_d;
    end
  end

  assign flags_out = flags_q;
  assign out_valid = vld_q;
  assign bad_class = bad_q;

endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk
  import cflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [CLASS_W-1:0] op_class,
  input logic [DATA_W-1:0]  res_op,
  input logic [DATA_W-1:0]  src_op,
  input logic [FLAG_W-1:0]  flags_in,
  input logic [FLAG_W-1:0]  flags_out,
  input logic               out_valid,
  input logic               bad_class
);

  AST_ANSWER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !bad_class && $stable(flags_out))); // R2

  AST_PRESET_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_class == CLS_PRESET) |=> (flags_out == $past(res_op[FLAG_W-1:0]))); // R3

  AST_LOGIC_VC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_class == CLS_LOGIC) |=> (flags_out[1:0] == 2'b00)); // R4

  AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_class != CLS_PRESET && op_class <= CLS_LAST)
      |=> !(flags_out[3] && flags_out[2])); // R4

  AST_STICKY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (op_class == CLS_ADDX || op_class == CLS_SUBX) && !flags_in[2])
      |=> !flags_out[2]); // R10

  AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_class == CLS_SHIFT)
      |=> (flags_out[0] == ($past(src_op) != '0) && flags_out[4] == flags_out[0])); // R11

  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_class > CLS_LAST) |=> (bad_class && flags_out == '0)); // R12

  AST_BAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_class |-> out_valid); // R12

endmodule

bind cond_flag_unit cond_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .op_class  (op_class),
  .res_op    (res_op),
  .src_op    (src_op),
  .flags_in  (flags_in),
  .flags_out (flags_out),
  .out_valid (out_valid),
  .bad_class (bad_class)
);

// File: tb/tb_cond_flag_unit.sv
`timescale 1ns/1ps
module tb_cond_flag_unit;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  op_class;
  logic [31:0] res_op;
  logic [31:0] src_op;
  logic [4:0]  flags_in;
  logic [4:0]  flags_out;
  logic        out_valid;
  logic        bad_class;

  int n_tests;
  int n_fail;
  bit done;

  cond_flag_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op_class  (op_class),
    .res_op    (res_op),
    .src_op    (src_op),
    .flags_in  (flags_in),
    .flags_out (flags_out),
    .out_valid (out_valid),
    .bad_class (bad_class)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5: return "R7";
      4'd6: return "R8";
      4'd7: return "R9";
      4'd8: return "R11";
      default: return "R12";
    endcase
  endfunction

  // Subtract at width w (8, 16 or 32): returns {N,Z,V,C}
  function automatic logic [3:0] sub_ref(input logic [31:0] r, input logic [31:0] s,
                                         input logic cin, input int w);
    logic [32:0] mnd, dif;
    logic [31:0] mask, rr, ss, mm;
    logic        b, v, n, z;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    rr   = r & mask;
    ss   = s & mask;
    mm   = (rr + ss + {31'b0, cin}) & mask;
    mnd  = {1'b0, mm};
    dif  = mnd - {1'b0, ss} - {32'b0, cin};
    b    = dif[32];
    v    = (mm[w-1] != ss[w-1]) && (rr[w-1] != mm[w-1]);
    z    = (rr == 0);
    n    = rr[w-1];
    return {n, z, v, b};
  endfunction

  // Add at 32 bits: returns {N,Z,V,C}
  function automatic logic [3:0] add_ref(input logic [31:0] r, input logic [31:0] s,
                                         input logic cin);
    logic [31:0] a;
    logic [32:0] sum;
    logic        v;
    a   = r - s - {31'b0, cin};
    sum = {1'b0, a} + {1'b0, s} + {32'b0, cin};
    v   = (a[31] == s[31]) && (r[31] != s[31]);
    return {r[31], (r == 0), v, sum[32]};
  endfunction

  // Expected {bad, X,N,Z,V,C}
  function automatic logic [5:0] ref_eval(input logic [3:0] c, input logic [31:0] r,
                                          input logic [31:0] s, input logic [4:0] f);
    logic [3:0] k;
    logic       xi, zi;
    xi = f[4];
    zi = f[2];
    case (c)
      4'd0: return {1'b0, r[4:0]};
      4'd1: return {1'b0, xi, r[31], (r == 0), 2'b00};
      4'd2: begin k = add_ref(r, s, 1'b0); return {1'b0, k[0], k}; end
      4'd3: begin k = sub_ref(r, s, 1'b0, 32); return {1'b0, k[0], k}; end
      4'd4: begin k = sub_ref(r, s, 1'b0, 8); return {1'b0, xi, k}; end
      4'd5: begin k = sub_ref(r, s, 1'b0, 16); return {1'b0, xi, k}; end
      4'd6: begin k = add_ref(r, s, xi); k[2] = k[2] & zi; return {1'b0, k[0], k}; end
      4'd7: begin k = sub_ref(r, s, xi, 32); k[2] = k[2] & zi; return {1'b0, k[0], k}; end
      4'd8: return {1'b0, (s != 0), r[31], (r == 0), 1'b0, (s != 0)};
      default: return 6'b10_0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [6:0] act,
                     input logic [6:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got {valid,bad,flags}=%b expected %b", tag, act, exp);
    end
  endtask

  // Called at a falling edge. Drives one request, checks the answer on the
  // next falling edge, then one idle cycle for the hold check.
  task automatic apply(input logic [3:0] c, input logic [31:0] r, input logic [31:0] s,
                       input logic [4:0] f);
    logic [5:0] e;
    logic [4:0] held;
    e         = ref_eval(c, r, s, f);
    req_valid = 1'b1;
    op_class  = c;
    res_op    = r;
    src_op    = s;
    flags_in  = f;
    @(negedge clk);
    req_valid = 1'b0;
    op_class  = $urandom % 16;
    res_op    = $urandom;
    src_op    = $urandom;
    flags_in  = $urandom;
    chk({out_valid, bad_class, flags_out} == {1'b1, e}, tag_of(c),
        {out_valid, bad_class, flags_out}, {1'b1, e});
    held = flags_out;
    @(negedge clk);
    chk({out_valid, bad_class, flags_out} == {2'b00, held}, "R2 hold",
        {out_valid, bad_class, flags_out}, {2'b00, held});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] fl;
    n_tests   = 0;
    n_fail    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    op_class  = '0;
    res_op    = '0;
    src_op    = '0;
    flags_in  = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk({out_valid, bad_class, flags_out} == 7'd0, "R1 in reset",
        {out_valid, bad_class, flags_out}, 7'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({out_valid, bad_class, flags_out} == 7'd0, "R1 after release",
        {out_valid, bad_class, flags_out}, 7'd0);

    // Directed corners
    apply(4'd0, 32'hFFFF_FFF5, 32'h0, 5'b00000);       // R3 preset
    apply(4'd1, 32'h8000_0000, 32'h1, 5'b10011);       // R4 logic negative
    apply(4'd1, 32'h0, 32'h0, 5'b00011);               // R4 logic zero
    apply(4'd2, 32'h8000_0000, 32'h1, 5'b00000);       // R5 signed overflow
    apply(4'd2, 32'h0, 32'h1, 5'b00000);               // R5 carry and zero
    apply(4'd3, 32'hFFFF_FFFF, 32'h1, 5'b00000);       // R6 borrow
    apply(4'd3, 32'h7FFF_FFFF, 32'h1, 5'b00000);       // R6 overflow
    apply(4'd4, 32'h1234_5680, 32'hFFFF_FF01, 5'b10000); // R7 byte
    apply(4'd4, 32'hFFFF_FF00, 32'h0000_0000, 5'b00000); // R7 byte zero
    apply(4'd5, 32'h0000_8000, 32'h0000_0001, 5'b10000); // R7 word
    apply(4'd6, 32'h0000_0005, 32'h0000_0005, 5'b10100); // R8 equal with carry
    apply(4'd6, 32'h0000_0005, 32'h0000_0005, 5'b00100); // R8 equal no carry
    apply(4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'b10100); // R9 with borrow
    apply(4'd7, 32'h0000_0000, 32'h0000_0000, 5'b10100); // R9 zero word
    apply(4'd8, 32'h0, 32'h0, 5'b11111);               // R11 no bit out
    apply(4'd8, 32'h8000_0000, 32'h1, 5'b00000);       // R11 bit out
    apply(4'd9, 32'h1F, 32'h1, 5'b11111);              // R12
    apply(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'b11111); // R12

    // R10: three-word chains, each word fed the previous answer
    for (int ch = 0; ch < 2; ch++) begin
      logic [3:0] cc;
      cc = (ch == 0) ? 4'd6 : 4'd7;
      fl = 5'b10100;
      apply(cc, 32'h0, 32'h0, fl);
      fl = flags_out;
      apply(cc, 32'h5, 32'h3, fl);
      fl = flags_out;
      apply(cc, 32'h0, 32'h0, fl);
      chk(flags_out[2] == 1'b0, "R10 sticky zero", {2'b00, flags_out}, {2'b00, flags_out & 5'b11011});
    end

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  c;
      logic [31:0] r, s;
      c = ($urandom % 8 == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
      r = $urandom;
      s = $urandom;
      case ($urandom % 6)
        0: r = 32'h0;
        1: s = r;
        2: s = 32'h0;
        3: r = r & 32'hFF;
        default: ;
      endcase
      apply(c, r, s, 5'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule